// File: doc/BRIEF.md
# Vertical Edge Enhancer with Coring

This block sharpens horizontal edges in a luma stream by looking across three vertically adjacent lines. For every pixel position it receives the sample above, the centre sample and the sample below. From these it forms a vertical detail term: the part of the centre sample that its two neighbours do not share. Small detail can be removed by an optional dead-zone (coring). The surviving detail is scaled by one of three fixed gains, or dropped, and added back onto the centre sample.

The result is then bounded. It never falls below a fixed pedestal code and never rises above full scale. The one exception is a centre sample at sync-tip level: it passes through unchanged, so sync pulses survive. The taps come from external line delays, which are not part of this block. The block has a fixed two-cycle pipeline, and a valid flag travels with the data.

Top module: `vert_edge_enh`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` and `out_luma` are both cleared to 0 by that edge.
- R2: A sample accepted with `in_valid` high appears on `out_luma` two rising edges later, with `out_valid` high in that same cycle. When `in_valid` is low, `out_valid` is low two edges later.
- R3: The detail term is d = floor((2·mid − up − down) / 2), computed as a signed value. Samples are unsigned 8-bit codes from 0 to 255.
- R4: Coring is on when `coring_n` is 0. With coring on, any d with |d| ≤ CORE_TH (default 4) becomes 0. With `coring_n` at 1, d is passed on unchanged.
- R5: With coring on and |d| > CORE_TH, the magnitude of d is reduced by CORE_TH and its sign is kept.
- R6: `gain_sel` picks the gain. 2'b00 gives no enhancement. 2'b01 adds the cored detail arithmetically shifted right by 4 bits (flooring). 2'b10 shifts it right by 3 bits. 2'b11 shifts it right by 2 bits.
- R7: When the centre sample is at or above SYNC_LVL (default 16), the output is never below PED_CODE (default 60). A sum under the pedestal is replaced by PED_CODE.
- R8: When the centre sample is below SYNC_LVL, the output equals the centre sample. Enhancement and pedestal limiting are both bypassed.
- R9: A sum above 255 saturates to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Taps are valid this cycle |
| luma_up | input | 8 | Luma from the line above |
| luma_mid | input | 8 | Luma from the centre line |
| luma_dn | input | 8 | Luma from the line below |
| gain_sel | input | 2 | Enhancement level: 00 off, 01 low, 10 mid, 11 high |
| coring_n | input | 1 | 0 enables coring, 1 disables it |
| out_valid | output | 1 | Output sample is valid |
| out_luma | output | 8 | Enhanced, limited luma |

## Verification
Flat columns, where all three lines are equal, must come out unchanged. Bright and dark centre lines give positive and negative detail, and the same tap set is repeated at each level select so the four shift amounts can be told apart. Detail values of exactly the threshold and one above it are run with coring enabled and disabled. This separates the dead-zone from the subtraction step and confirms the polarity of the enable. Three further cases steer the sum below the pedestal, above full scale, and into the sync-tip range, which tells the lower clip, the saturation and the bypass apart. Back-to-back and gapped valid samples then fix the latency.

// File: rtl/vee_pkg.sv
package vee_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } vee_level_e;

  localparam int SHIFT_LOW  = 4;
  localparam int SHIFT_MID  = 3;
  localparam int SHIFT_HIGH = 2;

endpackage

// File: rtl/vee_detail.sv
module vee_detail #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]        up,
  input  logic [DW-1:0]        mid,
  input  logic [DW-1:0]        dn,
  output logic signed [DW:0]   detail
);

  localparam int SW = DW + 2;

  logic signed [SW-1:0] twice_mid;
  logic signed [SW-1:0] ext_up;
  logic signed [SW-1:0] ext_dn;
  logic signed [SW-1:0] diff;

  // 2*mid - up - down needs two guard bits over the sample width
  always_comb begin
    twice_mid = {1'b0, mid, 1'b0};
    ext_up    = {2'b00, up};
    ext_dn    = {2'b00, dn};
    diff      = twice_mid - ext_up - ext_dn;
  end

  // dropping the LSB of a signed value is a flooring halve
  assign detail = diff[SW-1:1];

endmodule

// File: rtl/vee_coring.sv
module vee_coring #(
  parameter int DW      = 8,
  parameter int CORE_TH = 4
) (
  input  logic                 en,
  input  logic signed [DW:0]   din,
  output logic signed [DW:0]   dout
);

  localparam logic [DW:0]        TH_U = (DW+1)'(CORE_TH);
  localparam logic signed [DW:0] TH_S = (DW+1)'(CORE_TH);

  logic [DW:0] mag;

  always_comb begin
    mag = din[DW] ? 0 - din : din;
    if (!en) begin
      dout = din;
    end else if (mag <= TH_U) begin
      dout = '0;
    end else if (din[DW]) begin
      dout = din + TH_S;
    end else begin
      dout = din - TH_S;
    end
  end

endmodule

// File: rtl/vee_gain.sv
module vee_gain
  import vee_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]           sel,
  input  logic signed [DW:0]   din,
  output logic signed [DW:0]   dout
);

  always_comb begin
    unique case (vee_level_e'(sel))
      LVL_LOW:  dout = din >>> SHIFT_LOW;
      LVL_MID:  dout = din >>> SHIFT_MID;
      LVL_HIGH: dout = din >>> SHIFT_HIGH;
      default:  dout = '0;
    endcase
  end

endmodule

// File: rtl/vee_limit.sv
module vee_limit #(
  parameter int DW       = 8,
  parameter int PED_CODE = 60,
  parameter int SYNC_LVL = 16
) (
  input  logic [DW-1:0]        mid,
  input  logic signed [DW:0]   boost,
  output logic [DW-1:0]        dout
);

  localparam int SW = DW + 2;
  localparam logic [DW-1:0]        SYNC_C = DW'(SYNC_LVL);
  localparam logic signed [SW-1:0] PED_S  = SW'(PED_CODE);
  localparam logic signed [SW-1:0] MAX_S  = SW'((1 << DW) - 1);

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, mid}) + $signed({boost[DW], boost});
    if (mid < SYNC_C) begin
      dout = mid;
    end else if (sum < PED_S) begin
      dout = PED_S[DW-1:0];
    end else if (sum > MAX_S) begin
      dout = MAX_S[DW-1:0];
    end else begin
      dout = sum[DW-1:0];
    end
  end

endmodule

// File: rtl/vert_edge_enh.sv
module vert_edge_enh #(
  parameter int DW       = 8,
  parameter int CORE_TH  = 4,
  parameter int PED_CODE = 60,
  parameter int SYNC_LVL = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] luma_up,
  input  logic [DW-1:0] luma_mid,
  input  logic [DW-1:0] luma_dn,
  input  logic [1:0]    gain_sel,
  input  logic          coring_n,
  output logic          out_valid,
  output logic [DW-1:0] out_luma
);

  localparam logic [DW-1:0] SYNC_C = DW'(SYNC_LVL);
  localparam logic [DW-1:0] PED_C  = DW'(PED_CODE);
  localparam logic [DW:0]   TH_C   = (DW+1)'(CORE_TH);

  // ---------------- stage 1: detail and coring ----------------
  logic signed [DW:0] raw_detail;
  logic signed [DW:0] cored;
  logic [DW:0]        raw_mag;

  vee_detail #(.DW(DW)) u_detail (
    .up     (luma_up),
    .mid    (luma_mid),
    .dn     (luma_dn),
    .detail (raw_detail)
  );

  vee_coring #(.DW(DW), .CORE_TH(CORE_TH)) u_coring (
    .en   (!coring_n),
    .din  (raw_detail),
    .dout (cored)
  );

  assign raw_mag = raw_detail[DW] ? 0 - raw_detail : raw_detail;

  logic               s1_valid;
  logic [DW-1:0]      s1_mid;
  logic signed [DW:0] s1_core;
  logic [1:0]         s1_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mid   <= '0;
      s1_core  <= '0;
      s1_sel   <= 2'b00;
    end else begin
      s1_valid <= in_valid;
      s1_mid   <= luma_mid;
      s1_core  <= cored;
      s1_sel   <= gain_sel;
    end
  end

  AST_CORE_DEADZONE: assert property (@(posedge clk) disable iff (rst)
    (!coring_n && raw_mag <= TH_C) |=> (s1_core == 0)); // R4

  AST_CORE_BYPASS: assert property (@(posedge clk) disable iff (rst)
    coring_n |=> (s1_core == $past(raw_detail))); // R4

  AST_S1_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R2

  // ---------------- stage 2: gain and limiting ----------------
  logic signed [DW:0] boost;
  logic [DW-1:0]      limited;

  vee_gain #(.DW(DW)) u_gain (
    .sel  (s1_sel),
    .din  (s1_core),
    .dout (boost)
  );

  vee_limit #(.DW(DW), .PED_CODE(PED_CODE), .SYNC_LVL(SYNC_LVL)) u_limit (
    .mid   (s1_mid),
    .boost (boost),
    .dout  (limited)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_luma  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_luma  <= limited;
    end
  end

  AST_OUT_VALID: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid); // R2

  AST_PED_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mid >= SYNC_C) |=> (out_luma >= PED_C)); // R7

  AST_SYNC_PASS: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mid < SYNC_C) |=> (out_luma == $past(s1_mid))); // R8

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_sel == 2'b00 && s1_mid >= PED_C) |=> (out_luma == $past(s1_mid))); // R6

endmodule

// File: tb/vert_edge_enh_tb.sv
module vert_edge_enh_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] luma_up, luma_mid, luma_dn;
  logic [1:0]    gain_sel;
  logic          coring_n;
  logic          out_valid;
  logic [DW-1:0] out_luma;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vert_edge_enh u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .luma_up(luma_up), .luma_mid(luma_mid), .luma_dn(luma_dn),
    .gain_sel(gain_sel), .coring_n(coring_n),
    .out_valid(out_valid), .out_luma(out_luma)
  );

  function automatic int model(int up, int mid, int dn, int sel, bit cn);
    int d, c, e, s;
    d = (2*mid - up - dn) >>> 1;
    if (!cn) begin
      if (d <= 4 && d >= -4) c = 0;
      else if (d > 0) c = d - 4;
      else c = d + 4;
    end else c = d;
    case (sel)
      1: e = c >>> 4;
      2: e = c >>> 3;
      3: e = c >>> 2;
      default: e = 0;
    endcase
    if (mid < 16) return mid;
    s = mid + e;
    if (s < 60) s = 60;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int up, int mid, int dn, int sel, bit cn, bit v);
    luma_up  = DW'(up);
    luma_mid = DW'(mid);
    luma_dn  = DW'(dn);
    gain_sel = 2'(sel);
    coring_n = cn;
    in_valid = v;
  endtask

  // one isolated sample, checked two edges later
  task automatic one_sample(string req, int up, int mid, int dn, int sel, bit cn);
    @(negedge clk);
    drive(up, mid, dn, sel, cn, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, int'(out_valid), 1);
    check(req, int'(out_luma), model(up, mid, dn, sel, cn));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(0, 0, 0, 0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 luma", int'(out_luma), 0);
    rst = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic t_flat();
    for (int s = 0; s < 4; s++) one_sample("R3 flat", 120, 120, 120, s, 1'b1);
  endtask

  task automatic t_detail_sign();
    one_sample("R3 bright", 100, 140, 100, 3, 1'b1);
    one_sample("R3 dark", 200, 120, 200, 3, 1'b1);
    one_sample("R3 odd floor", 101, 140, 100, 3, 1'b1);
  endtask

  task automatic t_levels();
    for (int s = 0; s < 4; s++) begin
      one_sample("R6 pos", 100, 180, 100, s, 1'b1);
      one_sample("R6 neg", 200, 130, 190, s, 1'b1);
    end
  endtask

  task automatic t_coring();
    one_sample("R4 edge on", 100, 104, 100, 3, 1'b0);
    one_sample("R4 edge off", 100, 104, 100, 3, 1'b1);
    one_sample("R4 neg edge on", 100, 96, 100, 3, 1'b0);
    one_sample("R5 above on", 100, 120, 100, 3, 1'b0);
    one_sample("R5 below on", 140, 100, 140, 3, 1'b0);
    one_sample("R5 just over", 100, 105, 100, 3, 1'b0);
  endtask

  task automatic t_limits();
    one_sample("R7 clip", 120, 62, 120, 3, 1'b1);
    one_sample("R7 low flat", 30, 30, 30, 0, 1'b1);
    one_sample("R8 sync", 200, 10, 200, 3, 1'b1);
    one_sample("R8 sync zero", 0, 0, 0, 3, 1'b1);
    one_sample("R9 sat", 0, 250, 0, 3, 1'b1);
  endtask

  task automatic t_stream();
    @(negedge clk);
    drive(100, 180, 100, 3, 1'b1, 1'b1);
    @(negedge clk);
    drive(200, 130, 200, 2, 1'b1, 1'b1);
    @(negedge clk);
    drive(0, 0, 0, 0, 1'b1, 1'b0);
    check("R2 first", int'(out_valid), 1);
    check("R2 first data", int'(out_luma), model(100, 180, 100, 3, 1'b1));
    @(negedge clk);
    check("R2 second", int'(out_valid), 1);
    check("R2 second data", int'(out_luma), model(200, 130, 200, 2, 1'b1));
    @(negedge clk);
    check("R2 gap", int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_flat();
    t_detail_sign();
    t_levels();
    t_coring();
    t_limits();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule